// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a target on a two-wire I2C bus. It gives an external bus master byte-wide access to a 256-entry, 8-bit register array that sits inside the block. The bus lines reach the block as raw SCL and SDA levels, which the block oversamples on the system clock. The block answers by pulling SDA low through a single open-drain enable. A second, chip-side port lets local logic read and write the same array directly.

The first byte after a START carries a fixed 7-bit device address in its upper seven bits and a direction flag in bit 0. In a write transfer, the next byte loads an internal location pointer. Every byte after that is stored at the pointer. Reads return data from the pointer. The master can read from wherever the pointer was left, or load the pointer in a write transfer and then turn the bus around with a repeated START. Each byte moved over the bus advances the pointer by one. The pointer keeps its value between transfers.

Top module: `i2c_regif_target`

## Requirements
- R1: The block recognises a first byte after START whose bits [7:1] equal 7'b0011110 (0x1E). For that byte it pulls SDA low during the ninth SCL clock.
- R2: When the address does not match, the block never pulls SDA and writes no register until the next START or STOP.
- R3: When bit 0 of the device byte is 0 (write), the next byte is loaded into the location pointer, and the block acknowledges it.
- R4: In a write transfer, each byte after the pointer byte is stored at the pointer and acknowledged, and the pointer then advances by one. This repeats until STOP.
- R5: The pointer wraps from 0xFF to 0x00, for writes and for reads.
- R6: When bit 0 of the device byte is 1 (read), data is returned MSB first from the current pointer. The pointer keeps its value across transfers and STOPs.
- R7: A write-direction device byte, then a pointer byte, then a repeated START with a read-direction device byte returns data starting at the loaded pointer.
- R8: During a read, another byte follows each master acknowledge. After a master not-acknowledge the block releases SDA and drives nothing until START or STOP.
- R9: A START seen in any state, even in the middle of a byte, abandons the current byte and restarts device-address reception. A STOP returns the block to idle.
- R10: The SDA pull enable changes only while the synchronised SCL is low.
- R11: The chip-side port shows the addressed register on its read data output without a clock. A chip-side write takes effect at the next clock edge.
- R12: After reset the SDA pull is released, the pointer is 0x00 and every register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| host_addr | input | 8 | Chip-side register address |
| host_wdata | input | 8 | Chip-side write data |
| host_we | input | 1 | Chip-side write strobe |
| host_rdata | output | 8 | Chip-side read data for host_addr |

## Verification
The bench drives a single-byte write, a burst that crosses the 0xFF boundary, a current-address read, and a random read through a repeated START. Comparing the data read back shows whether the pointer is shared, whether it persists across transfers, and whether it wraps. A transfer to a foreign address, followed by data bytes, separates correct address matching from acknowledging everything. A START inserted halfway through a data byte shows whether a partial byte can leak into the array. A read that ends in a not-acknowledge, sampled before STOP, shows whether the block really lets go of the line.

// File: rtl/i2c_regif_pkg.sv
// Package: protocol states shared by the I2C register-access target.
// Assumes 8-bit bytes on the bus; nothing here depends on clock rate.
package i2c_regif_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,     // bus free, waiting for START
        ST_DEV,      // shifting in the device byte
        ST_DEV_ACK,  // acknowledging the device byte
        ST_SUB,      // shifting in the pointer byte
        ST_SUB_ACK,  // acknowledging the pointer byte
        ST_WR,       // shifting in a data byte
        ST_WR_ACK,   // acknowledging a data byte
        ST_RD,       // shifting out a data byte
        ST_RD_ACK,   // sampling the master's acknowledge
        ST_IGNORE    // not addressed or read finished: stay quiet
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: brings raw SCL/SDA into the clock domain through a
// parameterised flop chain, then derives SCL edges and START/STOP events.
// Assumes the system clock is several times faster than SCL.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;

    // Synchroniser chains: idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_in};
            sda_chain <= {sda_chain[STAGES-2:0], sda_in};
        end
    end

    // One-cycle history of the synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    // Event decode: SDA moving while SCL stays high marks START/STOP.
    always_comb begin
        scl_lvl   = scl_chain[STAGES-1];
        sda_lvl   = sda_chain[STAGES-1];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

endmodule

// File: rtl/i2c_reg_array.sv
// Module: register array with one port for the bus engine and one for
// chip-side logic. Reads are combinational; writes land at the clock
// edge. If both sides write one address in the same cycle, the bus wins.
module i2c_reg_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Storage update: clear on reset, host write first, bus write last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (host_we) begin
                mem[host_addr] <= host_wdata;
            end
            if (bus_we) begin
                mem[bus_addr] <= bus_wdata;
            end
        end
    end

    // Read ports: plain array lookup.
    always_comb begin
        bus_rdata  = mem[bus_addr];
        host_rdata = mem[host_addr];
    end

    // A bus byte takes nine SCL clocks, so writes never arrive back to back.
    AST_NO_BACK_TO_BACK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> !bus_we); // R4

endmodule

// File: rtl/i2c_target_fsm.sv
// Module: byte-level protocol engine. Shifts bytes in on SCL rising
// edges, drives data and acknowledges on SCL falling edges, and owns
// the shared location pointer. Assumes synchronised, edge-decoded inputs.
module i2c_target_fsm
    import i2c_regif_pkg::*;
#(
    parameter int           AW       = 8,
    parameter int           DW       = 8,
    parameter logic [6:0]   DEV_ADDR = 7'h1E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_lvl,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [DW-1:0] mem_rdata,
    output logic          sda_pull,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    localparam int          CW       = $clog2(DW + 1);
    localparam logic [CW-1:0] FULL   = CW'(DW);

    tgt_state_e    state;
    logic [CW-1:0] bitcnt;
    logic [DW-1:0] rx_sh;
    logic [DW-1:0] tx_sh;
    logic [AW-1:0] ptr;
    logic          rw_read;
    logic          master_ack;
    logic          byte_end;

    // Byte boundary: eight bits seen and SCL just went low.
    always_comb begin
        byte_end  = scl_fall && (bitcnt == FULL);
        mem_we    = (state == ST_WR) && byte_end && !start_det && !stop_det;
        mem_addr  = ptr;
        mem_wdata = rx_sh;
    end

    // Protocol sequencing, pointer and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            ptr        <= '0;
            rw_read    <= 1'b0;
            master_ack <= 1'b0;
            sda_pull   <= 1'b0;
        end else if (start_det) begin
            state    <= ST_DEV;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_SUB, ST_WR: begin
                    if (scl_rise && bitcnt != FULL) begin
                        rx_sh  <= {rx_sh[DW-2:0], sda_lvl};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_end) begin
                        bitcnt <= '0;
                        if (state == ST_DEV) begin
                            if (rx_sh[DW-1:1] == DEV_ADDR) begin
                                rw_read  <= rx_sh[0];
                                sda_pull <= 1'b1;
                                state    <= ST_DEV_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else if (state == ST_SUB) begin
                            ptr      <= rx_sh;
                            sda_pull <= 1'b1;
                            state    <= ST_SUB_ACK;
                        end else begin
                            ptr      <= ptr + 1'b1;
                            sda_pull <= 1'b1;
                            state    <= ST_WR_ACK;
                        end
                    end
                end
                ST_DEV_ACK, ST_SUB_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (state == ST_DEV_ACK && rw_read) begin
                            tx_sh    <= mem_rdata;
                            sda_pull <= ~mem_rdata[DW-1];
                            state    <= ST_RD;
                        end else begin
                            sda_pull <= 1'b0;
                            state    <= (state == ST_DEV_ACK) ? ST_SUB : ST_WR;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_rise && bitcnt != FULL) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_end) begin
                        sda_pull <= 1'b0;
                        ptr      <= ptr + 1'b1;
                        state    <= ST_RD_ACK;
                    end else if (scl_fall) begin
                        tx_sh    <= {tx_sh[DW-2:0], 1'b0};
                        sda_pull <= ~tx_sh[DW-2];
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        master_ack <= ~sda_lvl;
                    end else if (scl_fall) begin
                        bitcnt <= '0;
                        if (master_ack) begin
                            tx_sh    <= mem_rdata;
                            sda_pull <= ~mem_rdata[DW-1];
                            state    <= ST_RD;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                default: begin
                    sda_pull <= 1'b0;
                end
            endcase
        end
    end

    AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !$past(scl_lvl)); // R10
    AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_pull) && $past(state == ST_DEV)) |-> ($past(rx_sh[DW-1:1]) == DEV_ADDR)); // R1
    AST_QUIET_WHEN_IGNORING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_pull); // R2
    AST_PTR_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ptr) && $past(state) != ST_SUB) |-> (ptr == $past(ptr) + 1'b1)); // R5
    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= FULL); // R9

endmodule

// File: rtl/i2c_regif_target.sv
// Module: top of the I2C register-access target. Joins the line
// synchroniser, the protocol engine and the register array.
// Assumes an external pull-up; sda_pull=1 means drive SDA low.
module i2c_regif_target #(
    parameter int         AW          = 8,
    parameter int         DW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h1E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_pull,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_we,
    output logic [DW-1:0] host_rdata
);

    logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_target_fsm #(.AW(AW), .DW(DW), .DEV_ADDR(DEV_ADDR)) i_fsm (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .mem_rdata(mem_rdata), .sda_pull(sda_pull),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    i2c_reg_array #(.AW(AW), .DW(DW)) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(mem_we), .bus_addr(mem_addr),
        .bus_wdata(mem_wdata), .bus_rdata(mem_rdata), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

endmodule

// File: tb/test_i2c_regif_target.sv
module test_i2c_regif_target;

    localparam int Q = 10; // clocks per quarter SCL period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       msda = 1'b1;
    logic       sda_pull;
    logic [7:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_we = 1'b0;
    logic [7:0] host_rdata;
    wire        sda_line = msda & ~sda_pull;

    int n_chk = 0;
    int n_fail = 0;
    int r10_bad = 0;
    bit finished = 1'b0;

    typedef struct { string req; logic [7:0] val; } exp_t;
    exp_t       exp_q[$];
    logic [7:0] act_q[$];
    event       got_byte;

    always #4 clk = ~clk; // 125 MHz

    i2c_regif_target i_i2c_regif_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .host_rdata(host_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        msda = 1'b1; tick(Q);
        scl = 1'b1;  tick(Q);
        msda = 1'b0; tick(Q);
        scl = 1'b0;  tick(Q);
    endtask

    task automatic bus_stop();
        msda = 1'b0; tick(Q);
        scl = 1'b1;  tick(Q);
        msda = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        msda = b;   tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        msda = 1'b1; tick(Q);
        scl = 1'b1;  tick(Q);
        b = sda_line; tick(Q);
        scl = 1'b0;  tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~ack);
        act_q.push_back(v);
        -> got_byte;
    endtask

    task automatic expect_byte(input string req, input logic [7:0] v);
        exp_t e;
        e.req = req;
        e.val = v;
        exp_q.push_back(e);
    endtask

    task automatic host_read_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        host_addr = a;
        #1;
        check(req, host_rdata, exp);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Scoreboard monitor: compares each byte read from the bus.
    initial begin
        forever begin
            @(got_byte);
            while (act_q.size() > 0) begin
                logic [7:0] a;
                a = act_q.pop_front();
                if (exp_q.size() == 0) begin
                    check("R6 unexpected byte", a, 8'hxx);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.req, a, e.val);
                end
            end
        end
    end

    // R10: the pull must never move while SCL is high.
    logic pull_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_pull !== pull_prev && scl) r10_bad++;
        pull_prev <= sda_pull;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        summary();
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R12 reset state
        check("R12 pull released", sda_pull, 1'b0);
        host_read_check("R12 register cleared", 8'h05, 8'h00);

        // Single byte write
        bus_start();
        send_byte(8'h3C, ack); check("R1 device ack", ack, 1'b1);
        send_byte(8'h10, ack); check("R3 pointer ack", ack, 1'b1);
        send_byte(8'hA5, ack); check("R4 data ack", ack, 1'b1);
        bus_stop();
        host_read_check("R4 byte stored", 8'h10, 8'hA5);

        // Burst write across the wrap
        bus_start();
        send_byte(8'h3C, ack);
        send_byte(8'hFE, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack); check("R5 ack after wrap", ack, 1'b1);
        send_byte(8'h44, ack);
        bus_stop();
        host_read_check("R4 burst FE", 8'hFE, 8'h11);
        host_read_check("R4 burst FF", 8'hFF, 8'h22);
        host_read_check("R5 wrap 00", 8'h00, 8'h33);
        host_read_check("R5 wrap 01", 8'h01, 8'h44);

        // R11 host writes, then current-address read from pointer 0x02
        host_addr = 8'h02; host_wdata = 8'h5A; host_we = 1'b1; tick(1);
        host_addr = 8'h03; host_wdata = 8'hC3; tick(1);
        host_we = 1'b0;
        host_read_check("R11 host write", 8'h02, 8'h5A);
        bus_start();
        send_byte(8'h3D, ack); check("R6 read device ack", ack, 1'b1);
        expect_byte("R6 current read", 8'h5A);
        recv_byte(1'b1, d);
        expect_byte("R8 sequential read", 8'hC3);
        recv_byte(1'b0, d);
        tick(Q);
        check("R8 released after nack", sda_pull, 1'b0);
        send_byte(8'h00, ack); check("R8 quiet after nack", ack, 1'b0);
        bus_stop();

        // Random read through repeated START, wrapping the pointer
        bus_start();
        send_byte(8'h3C, ack);
        send_byte(8'hFE, ack);
        bus_start();
        send_byte(8'h3D, ack); check("R7 repeated start ack", ack, 1'b1);
        expect_byte("R7 random read", 8'h11);
        recv_byte(1'b1, d);
        expect_byte("R7 random read next", 8'h22);
        recv_byte(1'b1, d);
        expect_byte("R5 read wrap", 8'h33);
        recv_byte(1'b0, d);
        bus_stop();

        // Pointer persists: current read continues at 0x01
        bus_start();
        send_byte(8'h3D, ack);
        expect_byte("R6 pointer persists", 8'h44);
        recv_byte(1'b0, d);
        bus_stop();

        // Foreign address
        bus_start();
        send_byte(8'h40, ack); check("R2 no ack foreign", ack, 1'b0);
        send_byte(8'h10, ack); check("R2 no ack sub", ack, 1'b0);
        send_byte(8'hFF, ack); check("R2 no ack data", ack, 1'b0);
        bus_stop();
        host_read_check("R2 register untouched", 8'h10, 8'hA5);

        // START in mid-byte abandons it
        bus_start();
        send_byte(8'h3C, ack);
        send_byte(8'h20, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        send_byte(8'h3C, ack); check("R9 restart ack", ack, 1'b1);
        send_byte(8'h21, ack);
        send_byte(8'h77, ack);
        bus_stop();
        host_read_check("R9 partial byte dropped", 8'h20, 8'h00);
        host_read_check("R9 later write lands", 8'h21, 8'h77);

        tick(4);
        check("R10 pull stable while SCL high", r10_bad, 0);
        check("R6 all expected bytes seen", exp_q.size(), 0);
        summary();
    end

endmodule